// File: doc/BRIEF.md
# Asynchronous Schedule Advance Doorbell

This block gives software a safe point at which it may free or reuse queue heads it has unlinked from a circular asynchronous schedule. Software rings a doorbell after unlinking. The block then records which of its locally cached queue-head pointers are live. It watches the fetch stream of the schedule walker until every recorded pointer has been dropped. At that point it raises a status bit and clears the doorbell in the same update. A level interrupt follows the status bit when its enable is set.

The local pointer cache has four entries. A fetch that hits leaves the cache unchanged. A fetch that misses fills the lowest free entry or, when the cache is full, replaces a round-robin victim. A recorded entry counts as released when it is overwritten by a fetch of another address, or when the walker fetches the queue head that carries the head-of-list flag, since that marks one full lap of the ring. When the asynchronous schedule is disabled, the walker is idle and the whole cache counts as released.

Registers are reached through a simple write strobe with a register select and a single data bit, plus a combinational read port.

Top module: `async_advance_handshake`

## Requirements
- R1: After reset the doorbell, status and enable bits are 0, `irq` is 0 and every register reads 0.
- R2: Writing 1 to register select 0 sets the doorbell, which is visible after that edge. Writing 0 to it has no effect.
- R3: Status becomes 1 only at an edge where a pending doorbell completes, and that same edge clears the doorbell.
- R4: The snapshot holds the cache entries that are valid after the doorbell-write cycle's fetch. Completion happens at the edge where the last snapshot entry is released. An entry is released when a fetch of a different address overwrites it, or when any fetch has `fetch_head` = 1. Fetches that hit, or that fill a free entry, release nothing.
- R5: If the snapshot is empty, completion happens at the edge after the doorbell became visible, which is the second edge after the write.
- R6: The cache has 4 entries. A miss fills the lowest-numbered free entry. When the cache is full, a miss replaces the entry named by a round-robin pointer, which starts at entry 0 and advances by one after each replacement.
- R7: A doorbell write while a handshake is pending is ignored and does not reload the snapshot.
- R8: While `sched_en` = 0, fetches are ignored, the cache is emptied and a pending doorbell completes at that edge.
- R9: Writing 1 to register select 1 clears status, and writing 0 has no effect. If completion happens in the same cycle as the clear, status ends up 1.
- R10: Writing register select 2 loads the enable bit from `wr_bit`. `irq` equals status AND enable, in the same cycle as those bits.
- R11: `rd_data` bit 0 shows the doorbell for `rd_sel` = 0, status for 1 and enable for 2. Select 3 and all upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_en | input | 1 | Asynchronous schedule enabled; low means the walker is idle |
| fetch_valid | input | 1 | Walker fetched a queue head this cycle |
| fetch_addr | input | ADDR_W | Link address of the fetched queue head |
| fetch_head | input | 1 | Fetched queue head carries the head-of-list flag |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 doorbell, 1 status (write one to clear), 2 enable |
| wr_bit | input | 1 | Write data bit |
| rd_sel | input | 2 | Read select, same encoding as `wr_sel` |
| rd_data | output | DATA_W | Selected register, flag in bit 0 |
| irq | output | 1 | Level interrupt |

## Verification
A doorbell write shows in the doorbell bit one edge later. Completion, meaning status set, doorbell cleared and `irq` changed, lands at the same edge as the fetch or idle cycle that releases the last recorded entry. When nothing was recorded, it lands one edge after the doorbell shows. Status clears and enable writes take effect one edge after the write, while `rd_data` and `irq` are combinational from the registered bits. The bench drives inputs at the falling edge and predicts each register with a cycle-accurate model that is stepped at the rising edge. It compares at the next falling edge, so each result is sampled in exactly the cycle it is due, and directed sequences check the completion edge against hand-computed positions.

// File: rtl/aah_pkg.sv
package aah_pkg;

    // Register select encoding shared by the write and read ports.
    typedef enum logic [1:0] {
        SEL_DOORBELL = 2'd0,
        SEL_STATUS   = 2'd1,
        SEL_ENABLE   = 2'd2,
        SEL_UNUSED   = 2'd3
    } reg_sel_e;

    // Handshake register bits.
    typedef struct packed {
        logic doorbell;
        logic status;
        logic enable;
    } hs_regs_t;

endpackage

// File: rtl/aah_ptr_cache.sv
module aah_ptr_cache #(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned ADDR_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sched_en,
    input  logic               fetch_valid,
    input  logic [ADDR_W-1:0]  fetch_addr,
    output logic [ENTRIES-1:0] valid_next_o,
    output logic [ENTRIES-1:0] evict_o
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0][ADDR_W-1:0] addr;
        logic [ENTRIES-1:0]             valid;
        logic [IDX_W-1:0]               victim;
    } cache_t;

    cache_t             cache_d, cache_q;
    logic [ENTRIES-1:0] hit_vec;
    logic               free_found;
    logic [IDX_W-1:0]   free_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign hit_vec[g] = cache_q.valid[g] && (cache_q.addr[g] == fetch_addr);
    end

    always_comb begin
        cache_d    = cache_q;
        evict_o    = '0;
        free_found = 1'b0;
        free_idx   = '0;
        // Descending scan so the lowest free entry wins.
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!cache_q.valid[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        if (!sched_en) begin
            cache_d.valid = '0;
        end else if (fetch_valid && (hit_vec == '0)) begin
            if (free_found) begin
                cache_d.valid[free_idx] = 1'b1;
                cache_d.addr[free_idx]  = fetch_addr;
            end else begin
                evict_o[cache_q.victim]      = 1'b1;
                cache_d.addr[cache_q.victim] = fetch_addr;
                cache_d.victim = (cache_q.victim == IDX_W'(ENTRIES - 1)) ?
                                 '0 : cache_q.victim + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cache_q <= '0;
        else        cache_q <= cache_d;
    end

    assign valid_next_o = cache_d.valid;

endmodule

// File: rtl/aah_snapshot.sv
module aah_snapshot #(
    parameter int unsigned ENTRIES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic               pending,
    input  logic               sched_en,
    input  logic               head_fetch,
    input  logic [ENTRIES-1:0] evict,
    input  logic [ENTRIES-1:0] load_mask,
    output logic               done
);
    typedef struct packed {
        logic [ENTRIES-1:0] live;
    } snap_t;

    snap_t snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (capture) begin
            snap_d.live = load_mask;
        end else if (!pending || !sched_en) begin
            snap_d.live = '0;
        end else begin
            snap_d.live = snap_q.live & ~evict & {ENTRIES{~head_fetch}};
        end
        done = pending && (snap_d.live == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

endmodule

// File: rtl/async_advance_handshake.sv
module async_advance_handshake #(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sched_en,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_head,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic              wr_bit,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    import aah_pkg::*;

    hs_regs_t           regs_d, regs_q;
    logic [ENTRIES-1:0] valid_next;
    logic [ENTRIES-1:0] evict_vec;
    logic               capture;
    logic               head_fetch;
    logic               complete;
    logic               db_bit, sts_bit, ien_bit;

    assign capture    = wr_en && (reg_sel_e'(wr_sel) == SEL_DOORBELL) && wr_bit
                        && !regs_q.doorbell;
    assign head_fetch = sched_en && fetch_valid && fetch_head;

    aah_ptr_cache #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_cache (
        .clk          (clk),
        .rst_n        (rst_n),
        .sched_en     (sched_en),
        .fetch_valid  (fetch_valid),
        .fetch_addr   (fetch_addr),
        .valid_next_o (valid_next),
        .evict_o      (evict_vec)
    );

    aah_snapshot #(.ENTRIES(ENTRIES)) u_snap (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .pending    (regs_q.doorbell),
        .sched_en   (sched_en),
        .head_fetch (head_fetch),
        .evict      (evict_vec),
        .load_mask  (valid_next),
        .done       (complete)
    );

    always_comb begin
        regs_d = regs_q;
        if (complete)     regs_d.doorbell = 1'b0;
        else if (capture) regs_d.doorbell = 1'b1;
        if (complete) begin
            regs_d.status = 1'b1;
        end else if (wr_en && (reg_sel_e'(wr_sel) == SEL_STATUS) && wr_bit) begin
            regs_d.status = 1'b0;
        end
        if (wr_en && (reg_sel_e'(wr_sel) == SEL_ENABLE)) regs_d.enable = wr_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign db_bit  = regs_q.doorbell;
    assign sts_bit = regs_q.status;
    assign ien_bit = regs_q.enable;

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_sel))
            SEL_DOORBELL: rd_data[0] = db_bit;
            SEL_STATUS:   rd_data[0] = sts_bit;
            SEL_ENABLE:   rd_data[0] = ien_bit;
            default:      rd_data    = '0;
        endcase
    end

    assign irq = sts_bit && ien_bit;

endmodule

// File: rtl/aah_checker.sv
module aah_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sched_en,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic       wr_bit,
    input logic       db,
    input logic       sts,
    input logic       ien,
    input logic       irq
);
    // R2
    doorbell_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && wr_bit && !db) |=> db);

    // R3
    status_needs_doorbell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts) |-> ($past(db) && !db));

    // R8
    idle_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db && !sched_en) |=> (sts && !db));

    // R9
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && wr_bit && !db) |=> !sts);

    // R10
    irq_on_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sts) && ien && $stable(ien)) |-> irq);

endmodule

bind async_advance_handshake aah_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sched_en (sched_en),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_bit   (wr_bit),
    .db       (db_bit),
    .sts      (sts_bit),
    .ien      (ien_bit),
    .irq      (irq)
);

// File: tb/tb_async_advance_handshake.sv
module tb_async_advance_handshake;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sched_en, fetch_valid, fetch_head, wr_en, wr_bit;
    logic [31:0] fetch_addr;
    logic [1:0]  wr_sel, rd_sel;
    logic [7:0]  rd_data;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // Reference model state
    logic [31:0] m_addr [NE];
    logic [NE-1:0] m_valid, m_snap;
    int   m_rr;
    logic m_db, m_sts, m_ien;

    always #(CLK_PERIOD/2) clk = ~clk;

    async_advance_handshake dut (
        .clk(clk), .rst_n(rst_n), .sched_en(sched_en), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .fetch_head(fetch_head), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_bit(wr_bit), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [1:0] s);
        case (s)
            2'd0: return {7'b0, m_db};
            2'd1: return {7'b0, m_sts};
            2'd2: return {7'b0, m_ien};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] s);
        case (s)
            2'd0: return "R2";
            2'd1: return "R4";
            2'd2: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Read a register combinationally at the current (falling-edge) time.
    task automatic peek(input logic [1:0] s, output logic bitv);
        rd_sel = s;
        #1;
        bitv = rd_data[0];
    endtask

    // One clock: drive at falling edge, step model at rising edge, compare.
    task automatic step(input logic we, input logic [1:0] sel, input logic wb,
                        input logic fv, input logic [31:0] fa, input logic fh,
                        input logic se, input logic [1:0] rs);
        logic [NE-1:0] vn, ev, sn;
        logic [31:0]   an [NE];
        int            rrn;
        bit            hit, fe, he, cap, dn;
        int            fidx;
        wr_en = we; wr_sel = sel; wr_bit = wb;
        fetch_valid = fv; fetch_addr = fa; fetch_head = fh; sched_en = se; rd_sel = rs;
        vn = m_valid; ev = '0; rrn = m_rr;
        for (int i = 0; i < NE; i++) an[i] = m_addr[i];
        fe = fv && se;
        he = fe && fh;
        if (!se) begin
            vn = '0;
        end else if (fe) begin
            hit = 0;
            for (int i = 0; i < NE; i++) if (m_valid[i] && m_addr[i] == fa) hit = 1;
            if (!hit) begin
                fidx = -1;
                for (int i = NE - 1; i >= 0; i--) if (!m_valid[i]) fidx = i;
                if (fidx >= 0) begin
                    vn[fidx] = 1'b1; an[fidx] = fa;
                end else begin
                    ev[m_rr] = 1'b1; an[m_rr] = fa; rrn = (m_rr + 1) % NE;
                end
            end
        end
        cap = we && sel == 2'd0 && wb && !m_db;
        if (cap)               sn = vn;
        else if (!m_db || !se) sn = '0;
        else                   sn = m_snap & ~ev & {NE{~he}};
        dn = m_db && (sn == '0);
        @(posedge clk);
        m_valid = vn; m_snap = sn; m_rr = rrn;
        for (int i = 0; i < NE; i++) m_addr[i] = an[i];
        if (we && sel == 2'd2) m_ien = wb;
        if (dn) begin
            m_sts = 1'b1; m_db = 1'b0;
        end else begin
            if (cap) m_db = 1'b1;
            if (we && sel == 2'd1 && wb) m_sts = 1'b0;
        end
        @(negedge clk);
        check(rd_data == exp_rd(rs), tag_of(rs), "model rd_data", rd_data, exp_rd(rs));
        check(irq == (m_sts && m_ien), "R10", "model irq", irq, m_sts && m_ien);
    endtask

    task automatic idle();
        step(0, 2'd0, 0, 0, 32'h0, 0, 1, 2'd0);
    endtask

    task automatic fetch(input logic [31:0] a, input logic h);
        step(0, 2'd0, 0, 1, a, h, 1, 2'd1);
    endtask

    task automatic wr(input logic [1:0] s, input logic b);
        step(1, s, b, 0, 32'h0, 0, 1, 2'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
    end

    initial begin
        logic b;
        void'($urandom(32'd20240611));
        rst_n = 0; sched_en = 1; fetch_valid = 0; fetch_head = 0; fetch_addr = 0;
        wr_en = 0; wr_sel = 0; wr_bit = 0; rd_sel = 0;
        m_valid = '0; m_snap = '0; m_rr = 0; m_db = 0; m_sts = 0; m_ien = 0;
        for (int i = 0; i < NE; i++) m_addr[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s); #1;
            check(rd_data == 8'h00, "R1", "reset rd_data", rd_data, 0);
        end
        check(irq == 1'b0, "R1", "reset irq", irq, 0);

        // R2: writing zero to the doorbell has no effect
        wr(2'd0, 0);
        peek(2'd0, b); check(b == 0, "R2", "doorbell after zero write", b, 0);

        // R5: empty cache, doorbell completes one edge after it shows
        wr(2'd2, 1);
        wr(2'd0, 1);
        peek(2'd0, b); check(b == 1, "R2", "doorbell set", b, 1);
        peek(2'd1, b); check(b == 0, "R5", "status before completion", b, 0);
        idle();
        peek(2'd1, b); check(b == 1, "R5", "status after empty snapshot", b, 1);
        peek(2'd0, b); check(b == 0, "R3", "doorbell cleared with status", b, 0);
        check(irq == 1, "R10", "irq with enable", irq, 1);

        // R9: write one to clear
        wr(2'd1, 0);
        peek(2'd1, b); check(b == 1, "R9", "status after zero write", b, 1);
        wr(2'd1, 1);
        peek(2'd1, b); check(b == 0, "R9", "status cleared", b, 0);
        check(irq == 0, "R10", "irq after clear", irq, 0);

        // R4/R6: fill cache, hits and fills release nothing, evictions do
        fetch(32'h100, 0); fetch(32'h200, 0); fetch(32'h300, 0); fetch(32'h400, 0);
        wr(2'd0, 1);
        fetch(32'h100, 0);
        peek(2'd0, b); check(b == 1, "R4", "hit keeps pending", b, 1);
        fetch(32'h500, 0); fetch(32'h600, 0); fetch(32'h700, 0);
        peek(2'd1, b); check(b == 0, "R6", "three evictions still pending", b, 0);
        fetch(32'h800, 0);
        peek(2'd1, b); check(b == 1, "R6", "fourth eviction completes", b, 1);
        wr(2'd1, 1);

        // R4: head-of-list fetch that hits still releases all
        wr(2'd0, 1);
        fetch(32'h500, 1);
        peek(2'd1, b); check(b == 1, "R4", "head fetch completes", b, 1);
        wr(2'd1, 1);

        // R7: rewrite while pending does not reload the snapshot
        wr(2'd0, 1);
        fetch(32'h900, 0);
        wr(2'd0, 1);
        fetch(32'hA00, 0); fetch(32'hB00, 0);
        peek(2'd1, b); check(b == 0, "R7", "pending before last eviction", b, 0);
        fetch(32'hC00, 0);
        peek(2'd1, b); check(b == 1, "R7", "completes without restart", b, 1);
        wr(2'd1, 1);

        // R9: completion beats a same-cycle clear
        wr(2'd0, 1);
        step(1, 2'd1, 1, 1, 32'h900, 1, 1, 2'd1);
        check(rd_data[0] == 1, "R9", "set wins over clear", rd_data[0], 1);
        wr(2'd1, 1);

        // R8: idle schedule completes a pending doorbell and empties the cache
        wr(2'd0, 1);
        step(0, 2'd0, 0, 1, 32'hD00, 0, 0, 2'd1);
        check(rd_data[0] == 1, "R8", "idle completes", rd_data[0], 1);
        wr(2'd1, 1);
        wr(2'd0, 1);
        idle();
        peek(2'd1, b); check(b == 1, "R8", "cache emptied by idle", b, 1);
        wr(2'd1, 1);

        // R11: unused select reads zero
        peek(2'd3, b); check(rd_data == 8'h00, "R11", "select 3", rd_data, 0);

        // Constrained random against the model
        for (int n = 0; n < 4000; n++) begin
            int idx;
            logic we;
            idx = $urandom % 6;
            we  = ($urandom % 6) == 0;
            step(we, 2'($urandom % 3), 1'($urandom % 4 != 0),
                 1'($urandom % 2), 32'h1000 + 32'(idx) * 32'h10, idx == 0,
                 1'($urandom % 25 != 0), 2'($urandom % 4));
        end

        report();
    end
endmodule